// File: doc/BRIEF.md
# Co-processor Command Register with Completion Handshake

This block sits between a host and the command sequencer of a communication co-processor. The host writes one 16-bit word that carries an opcode, a channel number, a busy flag and a reset request. When the word is well formed and the block is idle, it hands the opcode and channel to the sequencer with a single-cycle valid pulse. It then keeps the busy flag at 1 in the readback word until the sequencer returns a single-cycle done pulse. Software learns that a command has finished by polling the flag until it reads 0.

A word that has both the reset bit and the busy flag set starts a co-processor reset sequence of fixed length instead of a command. During that sequence the flag reads 1. The block also rejects malformed words, ignores writes that arrive while a command is still in flight, and raises a timeout status when the sequencer takes longer than a programmable number of cycles. All status bits stay set until the next reset command.

Command word encoding: bit 0 is the busy flag, bits 7:4 the channel, bits 11:8 the opcode and bit 15 the reset request. Bits 3:1 and 14:12 are reserved and must be 0.

Top module: `cmdreg_handshake`

## Requirements
- R1: After the synchronous reset, `rd_data` is 0, and `cmd_valid`, `cp_reset` and all three status outputs are 0.
- R2: An idle write with bit 0 = 1, bit 15 = 0 and reserved bits 3:1 and 14:12 all 0 is accepted. In the cycle after the write edge, `cmd_valid` is 1 for exactly one cycle, `cmd_opcode` equals bits 11:8, `cmd_chan` equals bits 7:4, and `rd_data` reads back {bit15=0, opcode at 11:8, channel at 7:4, bit0=1}.
- R3: After an accepted command, `rd_data[0]` stays 1 until `seq_done` is sampled and reads 0 from the edge that samples it. A `seq_done` pulse while idle changes nothing.
- R4: An idle write with bit 0 = 0 has no effect: `rd_data` is unchanged and no `cmd_valid` pulse appears.
- R5: An idle write with bit 0 = 1 and any reserved bit (3:1 or 14:12) set is rejected. No pulse appears, the flag stays 0, and the sticky `st_invalid` output goes to 1.
- R6: Any write while `rd_data[0]` is 1 is ignored (fields unchanged, no pulse) and sets the sticky `st_overrun` output. This includes a write at the same edge as `seq_done`.
- R7: An idle write with bits 15 and 0 both set raises `cp_reset` for exactly RESET_CYCLES cycles. During that time `rd_data[15]` and `rd_data[0]` read 1 and `seq_done` is ignored. The sequence produces no `cmd_valid`, clears the stored opcode, channel and all three status bits, and ends with `rd_data` at 0.
- R8: With `timeout_limit` = L > 0, `st_timeout` sets at the L-th edge after the accepting edge if `seq_done` has not been sampled at any of edges 1..L. Done sampled at edge L or earlier does not set it.
- R9: `timeout_limit` = 0 disables the timeout however long completion takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 16 | Command word written by the host |
| rd_data | output | 16 | Readback: bit15 reset running, 11:8 opcode, 7:4 channel, bit0 busy flag |
| timeout_limit | input | CNT_W | Completion timeout in cycles, 0 disables |
| cmd_valid | output | 1 | One-cycle command launch pulse to the sequencer |
| cmd_opcode | output | 4 | Decoded opcode of the current command |
| cmd_chan | output | 4 | Decoded channel of the current command |
| seq_done | input | 1 | One-cycle completion pulse from the sequencer |
| cp_reset | output | 1 | High while the co-processor reset sequence runs |
| st_overrun | output | 1 | Sticky: write arrived while busy |
| st_invalid | output | 1 | Sticky: malformed command word rejected |
| st_timeout | output | 1 | Sticky: completion later than timeout_limit |

## Verification
A host write and the sequencer's done pulse can land on the same clock edge. The bench provokes this on purpose by asserting `wr_en` with a valid word in the very cycle it drives `seq_done`. The write is judged against the flag value before the edge, so the expected result is that the flag clears, `st_overrun` sets and no new `cmd_valid` follows. Done arriving exactly at the timeout edge is a second such collision, and it must not raise `st_timeout`.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 4;

    localparam int FLAG_BIT  = 0;
    localparam int RESET_BIT = 15;
    localparam int CHAN_LSB  = 4;
    localparam int OP_LSB    = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_RST  = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        logic               reset_req;
        logic [FIELD_W-1:0] opcode;
        logic [FIELD_W-1:0] chan;
        logic               flag;
        logic               malformed;
    } cmd_fields_t;

    function automatic cmd_fields_t split_word(input logic [WORD_W-1:0] w);
        cmd_fields_t f;
        f.flag      = w[FLAG_BIT];
        f.reset_req = w[RESET_BIT];
        f.chan      = w[CHAN_LSB +: FIELD_W];
        f.opcode    = w[OP_LSB +: FIELD_W];
        f.malformed = (w[3:1] != 3'b000) || (w[14:12] != 3'b000);
        return f;
    endfunction

endpackage

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
    import cmdreg_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_fields_t       fields
);
    always_comb fields = split_word(word);
endmodule

// File: rtl/cmdreg_timer.sv
module cmdreg_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    assign armed  = (limit != '0);
    assign expire = run && armed && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (run && armed && (cnt != limit)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cmdreg_ctrl.sv
module cmdreg_ctrl
    import cmdreg_pkg::*;
#(
    parameter int RESET_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  cmd_fields_t        fields,
    input  logic               seq_done,
    input  logic               expire,
    output logic               launch,
    output logic               busy,
    output logic               in_cmd,
    output logic               cp_reset,
    output logic               cmd_valid,
    output logic [FIELD_W-1:0] opcode,
    output logic [FIELD_W-1:0] chan,
    output logic               overrun,
    output logic               invalid,
    output logic               timeout
);
    localparam int RC_W = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES) : 1;
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RESET_CYCLES - 1);

    ctrl_state_e     state;
    logic [RC_W-1:0] rcnt;
    logic            idle_take;

    assign idle_take = (state == ST_IDLE) && wr_en && fields.flag && !fields.malformed;
    assign launch    = idle_take && !fields.reset_req;
    assign busy      = (state != ST_IDLE);
    assign in_cmd    = (state == ST_CMD);
    assign cp_reset  = (state == ST_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rcnt      <= '0;
            cmd_valid <= 1'b0;
            opcode    <= '0;
            chan      <= '0;
            overrun   <= 1'b0;
            invalid   <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (expire) timeout <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (wr_en && fields.flag) begin
                        if (fields.malformed) begin
                            invalid <= 1'b1;
                        end else if (fields.reset_req) begin
                            state   <= ST_RST;
                            rcnt    <= '0;
                            opcode  <= '0;
                            chan    <= '0;
                            overrun <= 1'b0;
                            invalid <= 1'b0;
                            timeout <= 1'b0;
                        end else begin
                            state     <= ST_CMD;
                            opcode    <= fields.opcode;
                            chan      <= fields.chan;
                            cmd_valid <= 1'b1;
                        end
                    end
                end
                ST_CMD: begin
                    if (wr_en) overrun <= 1'b1;
                    if (seq_done) state <= ST_IDLE;
                end
                ST_RST: begin
                    if (wr_en) overrun <= 1'b1;
                    if (rcnt == RC_LAST) state <= ST_IDLE;
                    else rcnt <= rcnt + RC_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmdreg_handshake.sv
module cmdreg_handshake
    import cmdreg_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int RESET_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data,
    input  logic [CNT_W-1:0] timeout_limit,
    output logic             cmd_valid,
    output logic [3:0]       cmd_opcode,
    output logic [3:0]       cmd_chan,
    input  logic             seq_done,
    output logic             cp_reset,
    output logic             st_overrun,
    output logic             st_invalid,
    output logic             st_timeout
);
    cmd_fields_t fields;
    logic        launch, busy, in_cmd, expire;

    cmdreg_decode u_dec (
        .word   (wr_data),
        .fields (fields)
    );

    cmdreg_ctrl #(.RESET_CYCLES(RESET_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .fields    (fields),
        .seq_done  (seq_done),
        .expire    (expire),
        .launch    (launch),
        .busy      (busy),
        .in_cmd    (in_cmd),
        .cp_reset  (cp_reset),
        .cmd_valid (cmd_valid),
        .opcode    (cmd_opcode),
        .chan      (cmd_chan),
        .overrun   (st_overrun),
        .invalid   (st_invalid),
        .timeout   (st_timeout)
    );

    cmdreg_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (launch),
        .run    (in_cmd && !seq_done),
        .limit  (timeout_limit),
        .expire (expire)
    );

    assign rd_data = {cp_reset, 3'b000, cmd_opcode, cmd_chan, 3'b000, busy};
endmodule

// File: rtl/cmdreg_handshake_chk.sv
module cmdreg_handshake_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        cmd_valid,
    input logic        seq_done,
    input logic        cp_reset,
    input logic        st_overrun,
    input logic        st_invalid
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R2

    AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (rd_data[0] && !rd_data[15])); // R2

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[0] && !cp_reset && !seq_done) |=> rd_data[0]); // R3

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[0] && !cp_reset && seq_done) |=> !rd_data[0]); // R3

    AST_BUSY_WRITE_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_data[0]) |=> (st_overrun && !cmd_valid)); // R6

    AST_REJECT_MALFORMED: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[0] && wr_en && wr_data[0] &&
         ((wr_data[3:1] != 3'b000) || (wr_data[14:12] != 3'b000)))
        |=> (st_invalid && !cmd_valid && !rd_data[0])); // R5

    AST_RESET_READS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cp_reset |-> (rd_data[15] && rd_data[0])); // R7
endmodule

bind cmdreg_handshake cmdreg_handshake_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .cmd_valid  (cmd_valid),
    .seq_done   (seq_done),
    .cp_reset   (cp_reset),
    .st_overrun (st_overrun),
    .st_invalid (st_invalid)
);

// File: tb/cmdreg_handshake_test.sv
`timescale 1ns/1ps
module cmdreg_handshake_test;
    localparam int CNT_W = 16;
    localparam int RC    = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [15:0]      wr_data = '0;
    logic [15:0]      rd_data;
    logic [CNT_W-1:0] timeout_limit = '0;
    logic             cmd_valid;
    logic [3:0]       cmd_opcode, cmd_chan;
    logic             seq_done = 1'b0;
    logic             cp_reset, st_overrun, st_invalid, st_timeout;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmdreg_handshake #(.CNT_W(CNT_W), .RESET_CYCLES(RC)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .timeout_limit(timeout_limit), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_chan(cmd_chan), .seq_done(seq_done), .cp_reset(cp_reset),
        .st_overrun(st_overrun), .st_invalid(st_invalid), .st_timeout(st_timeout)
    );

    function automatic logic [15:0] cmd_word(input logic [3:0] op, input logic [3:0] ch);
        return {4'b0000, op, ch, 4'b0001};
    endfunction

    function automatic logic [15:0] busy_readback(input logic [3:0] op, input logic [3:0] ch);
        return {4'b0000, op, ch, 4'b0001};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic done_at(input int d);
        repeat (d - 1) @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
    endtask

    task automatic run_reset_cmd();
        write_word(16'h8001);
        for (int i = 0; i < RC; i++) begin
            check("R7 cp_reset high", {31'd0, cp_reset}, 32'd1);
            check("R7 flag and bit15", {16'd0, rd_data}, 32'h8001);
            check("R7 no cmd_valid", {31'd0, cmd_valid}, 32'd0);
            seq_done = (i == 3);
            @(negedge clk);
        end
        seq_done = 1'b0;
        check("R7 cp_reset released", {31'd0, cp_reset}, 32'd0);
        check("R7 readback cleared", {16'd0, rd_data}, 32'd0);
        check("R7 status cleared", {29'd0, st_overrun, st_invalid, st_timeout}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] op, ch;
        int d, lim;
        bit exp_to;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 readback", {16'd0, rd_data}, 32'd0);
        check("R1 outputs", {27'd0, cmd_valid, cp_reset, st_overrun, st_invalid, st_timeout}, 32'd0);

        // R2 / R3 directed command
        write_word(cmd_word(4'hA, 4'h5));
        check("R2 cmd_valid", {31'd0, cmd_valid}, 32'd1);
        check("R2 opcode/chan", {24'd0, cmd_opcode, cmd_chan}, 32'hA5);
        check("R2 readback", {16'd0, rd_data}, {16'd0, busy_readback(4'hA, 4'h5)});
        @(negedge clk);
        check("R2 single pulse", {31'd0, cmd_valid}, 32'd0);
        check("R3 flag held", {31'd0, rd_data[0]}, 32'd1);
        done_at(3);
        check("R3 flag cleared", {31'd0, rd_data[0]}, 32'd0);

        // R3 done while idle
        seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;
        check("R3 idle done ignored", {16'd0, rd_data}, 32'h0A50);

        // R4 flag clear write
        write_word(16'h0370);
        check("R4 no pulse", {31'd0, cmd_valid}, 32'd0);
        check("R4 readback unchanged", {16'd0, rd_data}, 32'h0A50);

        // R5 malformed
        write_word(16'h0135);
        check("R5 no pulse", {31'd0, cmd_valid}, 32'd0);
        check("R5 flag stays 0", {31'd0, rd_data[0]}, 32'd0);
        check("R5 invalid sticky", {31'd0, st_invalid}, 32'd1);
        write_word(16'h2131);
        check("R5 high reserved rejected", {31'd0, rd_data[0]}, 32'd0);

        // R6 overrun
        write_word(cmd_word(4'h3, 4'hC));
        write_word(cmd_word(4'h7, 4'h1));
        check("R6 no second pulse", {31'd0, cmd_valid}, 32'd0);
        check("R6 fields unchanged", {24'd0, cmd_opcode, cmd_chan}, 32'h3C);
        check("R6 overrun sticky", {31'd0, st_overrun}, 32'd1);
        done_at(2);

        // R7 reset command clears status
        run_reset_cmd();

        // R6 / R3 collision: write and done at the same edge
        write_word(cmd_word(4'h5, 4'h9));
        @(negedge clk);
        seq_done = 1'b1; wr_en = 1'b1; wr_data = cmd_word(4'hE, 4'h2);
        @(negedge clk);
        seq_done = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R3 collision flag cleared", {31'd0, rd_data[0]}, 32'd0);
        check("R6 collision overrun", {31'd0, st_overrun}, 32'd1);
        check("R6 collision no pulse", {31'd0, cmd_valid}, 32'd0);
        check("R6 collision fields", {24'd0, cmd_opcode, cmd_chan}, 32'h59);

        // R8 timeout boundary
        timeout_limit = 16'd4;
        write_word(cmd_word(4'h1, 4'h1));
        done_at(4);
        check("R8 done at limit no timeout", {31'd0, st_timeout}, 32'd0);
        write_word(cmd_word(4'h2, 4'h2));
        repeat (4) @(negedge clk);
        check("R8 timeout set", {31'd0, st_timeout}, 32'd1);
        check("R8 flag still busy", {31'd0, rd_data[0]}, 32'd1);
        done_at(1);
        run_reset_cmd();

        // R9 disabled timeout
        timeout_limit = 16'd0;
        write_word(cmd_word(4'h6, 4'h6));
        done_at(40);
        check("R9 no timeout when disabled", {31'd0, st_timeout}, 32'd0);

        // Random commands against a model
        exp_to = 1'b0;
        for (int n = 0; n < 60; n++) begin
            op  = 4'($urandom_range(0, 15));
            ch  = 4'($urandom_range(0, 15));
            d   = $urandom_range(1, 12);
            lim = $urandom_range(0, 10);
            timeout_limit = CNT_W'(lim);
            write_word(cmd_word(op, ch));
            check("R2 random pulse", {31'd0, cmd_valid}, 32'd1);
            check("R2 random fields", {24'd0, cmd_opcode, cmd_chan}, {24'd0, op, ch});
            done_at(d);
            if (lim != 0 && d > lim) exp_to = 1'b1;
            check("R3 random flag cleared", {31'd0, rd_data[0]}, 32'd0);
            check("R8 random timeout", {31'd0, st_timeout}, {31'd0, exp_to});
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule